// File: doc/BRIEF.md
# Load-Use Interlock Unit

This block is the issue interlock of a five-stage integer pipeline. It sits beside the decode stage and compares two instructions. The first is the one now being decoded, held in the fetch/decode register. The second is the one just issued, held in the decode/execute register. If the older instruction is a load, the younger one may need the loaded value before the forwarding network can supply it. In that case the unit holds the younger instruction in decode for one cycle. During that cycle the program counter and the fetch/decode register are frozen, and the control portion of the decode/execute register is replaced by a no-op.

The instruction header uses a fixed layout. The operation code is in bits [31:26]. Source field A is in bits [25:21]. Field B is in bits [20:16], and field B is also the destination field of a load. Store data that matches a load destination is normally served by the late forwarding path into the data memory input, so it costs no stall. A parameter can switch that relief off for pipelines that lack the path. The unit also keeps one bit of history, so that one conflict never produces two bubbles back to back.

Top module: `lu_interlock`

## Requirements
- R1: A stall is raised when the decode/execute instruction is a load (operation bits [31:29] = 3'b100) and its field B equals field A of the decoding instruction, for any decoding instruction class that reads field A. An older instruction that is not a load never causes a stall.
- R2: A match on field B also stalls when the decoding instruction reads field B as an operand. This applies to the register-register class (operation 6'b000000) and to the compare-branch class (operations 6'b000100 and 6'b000101).
- R3: In the store class (operation bits [31:29] = 3'b101), field B is store data. With STORE_FWD=1 (the default), a match on that field does not stall. With STORE_FWD=0, it stalls. A match on the base field A stalls in both cases.
- R4: A load whose field B is 0 never causes a stall.
- R5: No stall is raised unless both ifid_valid and idex_valid are 1.
- R6: Some classes read no register: the jumps (operations 6'b000010 and 6'b000011), the upper-immediate class (6'b001111) and any unlisted operation. These never stall. The immediate ALU class (bits [31:29] = 3'b001, excluding 6'b001111) and the load class read field A only.
- R7: In a stall cycle, pc_we=0, ifid_we=0 and idex_bubble=1. In every other cycle, pc_we=1, ifid_we=1 and idex_bubble=0. The outputs respond to the inputs in the same cycle.
- R8: The cycle after a stall cycle never stalls, so each conflict inserts exactly one bubble and the held instruction then issues.
- R9: While rst is 1, no stall is raised. A synchronous reset clears the stall history, so a conflict presented right after reset stalls at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ifid_instr | input | 32 | Instruction being decoded |
| ifid_valid | input | 1 | Decoding instruction is valid |
| idex_instr | input | 32 | Instruction in the decode/execute register |
| idex_valid | input | 1 | Decode/execute instruction is valid |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| idex_bubble | output | 1 | Force decode/execute control fields to a no-op |

## Verification
The assertions assume that both instruction inputs and both valid bits stay stable across each clock edge. They also assume that a valid bit of 0 marks the paired instruction as irrelevant, whatever its bits hold. The bench keeps to this by driving every input only at the falling edge. It draws random register fields from a small range, so that matches between the two instructions happen often, and it mixes occasional invalid slots and resets into the random stream.

// File: rtl/lu_interlock_pkg.sv
package lu_interlock_pkg;

    localparam int INSTR_W  = 32;
    localparam int OPC_W    = 6;
    localparam int REG_W    = 5;
    localparam int GRP_W    = 3;
    localparam int OPC_LSB  = INSTR_W - OPC_W;
    localparam int SRCA_LSB = OPC_LSB - REG_W;
    localparam int SRCB_LSB = SRCA_LSB - REG_W;
    localparam int HDR_W    = INSTR_W - SRCB_LSB;

    typedef logic [REG_W-1:0] reg_idx_t;
    typedef logic [OPC_W-1:0] opc_t;
    typedef logic [HDR_W-1:0] hdr_t;

    localparam opc_t     OPC_REGREG = 6'b000000;
    localparam opc_t     OPC_JMP    = 6'b000010;
    localparam opc_t     OPC_JMPL   = 6'b000011;
    localparam opc_t     OPC_BREQ   = 6'b000100;
    localparam opc_t     OPC_BRNE   = 6'b000101;
    localparam opc_t     OPC_UPIMM  = 6'b001111;
    localparam logic [GRP_W-1:0] GRP_ALUIMM = 3'b001;
    localparam logic [GRP_W-1:0] GRP_LOAD   = 3'b100;
    localparam logic [GRP_W-1:0] GRP_STORE  = 3'b101;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_REGREG,
        CLS_CMPBR,
        CLS_LOAD,
        CLS_STORE,
        CLS_ALUIMM
    } op_class_t;

    typedef struct packed {
        op_class_t cls;
        logic      reads_a;
        logic      reads_b;
        logic      b_is_sdata;
        reg_idx_t  a_idx;
        reg_idx_t  b_idx;
    } dec_t;

    function automatic op_class_t classify(opc_t op);
        op_class_t c;
        if (op == OPC_REGREG)
            c = CLS_REGREG;
        else if (op == OPC_BREQ || op == OPC_BRNE)
            c = CLS_CMPBR;
        else begin
            case (op[OPC_W-1 -: GRP_W])
                GRP_LOAD:   c = CLS_LOAD;
                GRP_STORE:  c = CLS_STORE;
                GRP_ALUIMM: c = (op == OPC_UPIMM) ? CLS_NONE : CLS_ALUIMM;
                default:    c = CLS_NONE;
            endcase
        end
        return c;
    endfunction

    function automatic dec_t decode(hdr_t hdr);
        dec_t d;
        d.cls        = classify(hdr[HDR_W-1 -: OPC_W]);
        d.a_idx      = hdr[HDR_W-OPC_W-1 -: REG_W];
        d.b_idx      = hdr[REG_W-1:0];
        d.reads_a    = (d.cls != CLS_NONE);
        d.reads_b    = (d.cls == CLS_REGREG) || (d.cls == CLS_CMPBR) ||
                       (d.cls == CLS_STORE);
        d.b_is_sdata = (d.cls == CLS_STORE);
        return d;
    endfunction

endpackage

// File: rtl/lu_instr_decode.sv
module lu_instr_decode
    import lu_interlock_pkg::*;
(
    input  hdr_t hdr,
    output dec_t dec
);

    always_comb begin
        dec = decode(hdr);
    end

endmodule

// File: rtl/lu_hazard_match.sv
module lu_hazard_match
    import lu_interlock_pkg::*;
#(
    parameter bit STORE_FWD = 1'b1
) (
    input  dec_t prod,
    input  logic prod_valid,
    input  dec_t cons,
    input  logic cons_valid,
    output logic raw_hazard
);

    logic dest_live;
    logic b_needed;
    logic hit_a;
    logic hit_b;

    // Only a valid load with a non-zero destination can create a conflict.
    assign dest_live = prod_valid && cons_valid &&
                       (prod.cls == CLS_LOAD) && (prod.b_idx != '0);

    generate
        if (STORE_FWD) begin : g_store_fwd
            // Store data is picked up later by the memory-input forward path.
            assign b_needed = cons.reads_b && !cons.b_is_sdata;
        end else begin : g_store_nofwd
            assign b_needed = cons.reads_b;
        end
    endgenerate

    assign hit_a      = dest_live && cons.reads_a && (cons.a_idx == prod.b_idx);
    assign hit_b      = dest_live && b_needed     && (cons.b_idx == prod.b_idx);
    assign raw_hazard = hit_a || hit_b;

endmodule

// File: rtl/lu_interlock.sv
module lu_interlock
    import lu_interlock_pkg::*;
#(
    parameter bit STORE_FWD = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] ifid_instr,
    input  logic        ifid_valid,
    input  logic [31:0] idex_instr,
    input  logic        idex_valid,
    output logic        pc_we,
    output logic        ifid_we,
    output logic        idex_bubble
);

    localparam int NSTAGE = 2;
    localparam int ST_ID  = 0;
    localparam int ST_EX  = 1;

    logic [INSTR_W-1:0] stage_instr [NSTAGE];
    dec_t               stage_dec   [NSTAGE];
    logic               raw_hazard;
    logic               stall;
    logic               bubble_q;
    logic               unused_lo;

    assign stage_instr[ST_ID] = ifid_instr;
    assign stage_instr[ST_EX] = idex_instr;
    assign unused_lo = ^{ifid_instr[SRCB_LSB-1:0], idex_instr[SRCB_LSB-1:0]};

    for (genvar s = 0; s < NSTAGE; s++) begin : g_dec
        lu_instr_decode u_dec (
            .hdr (stage_instr[s][INSTR_W-1:SRCB_LSB]),
            .dec (stage_dec[s])
        );
    end

    lu_hazard_match #(.STORE_FWD(STORE_FWD)) u_match (
        .prod       (stage_dec[ST_EX]),
        .prod_valid (idex_valid),
        .cons       (stage_dec[ST_ID]),
        .cons_valid (ifid_valid),
        .raw_hazard (raw_hazard)
    );

    // The held instruction always issues in the cycle after a bubble.
    assign stall       = !rst && raw_hazard && !bubble_q;
    assign pc_we       = !stall;
    assign ifid_we     = !stall;
    assign idex_bubble = stall;

    always_ff @(posedge clk) begin
        if (rst) bubble_q <= 1'b0;
        else     bubble_q <= stall;
    end

    AST_STALL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (rst)
        idex_bubble |-> (idex_valid && stage_dec[ST_EX].cls == CLS_LOAD)); // R1
    AST_ZERO_DEST_QUIET: assert property (@(posedge clk) disable iff (rst)
        (stage_dec[ST_EX].b_idx == '0) |-> !idex_bubble); // R4
    AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!ifid_valid || !idex_valid) |-> !idex_bubble); // R5
    AST_NOREAD_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!stage_dec[ST_ID].reads_a && !stage_dec[ST_ID].reads_b) |-> !idex_bubble); // R6
    AST_FROZEN_ON_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        idex_bubble |-> (!pc_we && !ifid_we)); // R7
    AST_SINGLE_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        idex_bubble |=> !idex_bubble); // R8
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> !bubble_q); // R9

    generate
        if (STORE_FWD) begin : g_chk_store
            AST_STORE_DATA_FREE: assert property (@(posedge clk) disable iff (rst)
                (stage_dec[ST_ID].cls == CLS_STORE &&
                 stage_dec[ST_ID].a_idx != stage_dec[ST_EX].b_idx) |-> !idex_bubble); // R3
        end
    endgenerate

endmodule

// File: tb/tb_lu_interlock.sv
module tb_lu_interlock;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] ifid_instr, idex_instr;
    logic        ifid_valid, idex_valid;
    logic        pc_we_f, ifid_we_f, bub_f;
    logic        pc_we_n, ifid_we_n, bub_n;

    int n_vec  = 0;
    int n_fail = 0;
    bit hist_f = 1'b0;
    bit hist_n = 1'b0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lu_interlock #(.STORE_FWD(1'b1)) dut (
        .clk(clk), .rst(rst),
        .ifid_instr(ifid_instr), .ifid_valid(ifid_valid),
        .idex_instr(idex_instr), .idex_valid(idex_valid),
        .pc_we(pc_we_f), .ifid_we(ifid_we_f), .idex_bubble(bub_f)
    );

    lu_interlock #(.STORE_FWD(1'b0)) dut_nf (
        .clk(clk), .rst(rst),
        .ifid_instr(ifid_instr), .ifid_valid(ifid_valid),
        .idex_instr(idex_instr), .idex_valid(idex_valid),
        .pc_we(pc_we_n), .ifid_we(ifid_we_n), .idex_bubble(bub_n)
    );

    function automatic logic [31:0] mk(logic [5:0] op, logic [4:0] a, logic [4:0] b);
        return {op, a, b, 16'h1234};
    endfunction

    // Expected raw conflict, written from the requirements.
    function automatic bit model_raw(logic [31:0] c, bit cv, logic [31:0] p, bit pv, bit fwd);
        logic [5:0] cop = c[31:26];
        logic [4:0] dst = p[20:16];
        bit rd_a, rd_b, is_st;
        if (!cv || !pv) return 0;
        if (p[31:29] != 3'b100 || dst == 5'd0) return 0;
        is_st = (cop[5:3] == 3'b101);
        rd_b  = (cop == 6'b000000) || (cop == 6'b000100) || (cop == 6'b000101) ||
                (is_st && !fwd);
        rd_a  = (cop == 6'b000000) || (cop == 6'b000100) || (cop == 6'b000101) ||
                (cop[5:3] == 3'b100) || is_st ||
                (cop[5:3] == 3'b001 && cop != 6'b001111);
        return (rd_a && c[25:21] == dst) || (rd_b && c[20:16] == dst);
    endfunction

    task automatic chk(string tag, bit exp, logic pw, logic iw, logic bb);
        n_vec++;
        if (pw !== !exp || iw !== !exp || bb !== exp) begin
            n_fail++;
            $display("FAIL %s: pc_we=%0b ifid_we=%0b bubble=%0b expected pc_we=%0b ifid_we=%0b bubble=%0b",
                     tag, pw, iw, bb, !exp, !exp, exp);
        end
    endtask

    // Drive at the falling edge, check the same-cycle response, then advance history.
    task automatic apply(bit r, logic [31:0] c, bit cv, logic [31:0] p, bit pv,
                         string tag, int want_f = -1, int want_n = -1);
        bit ef, en;
        @(negedge clk);
        rst = r; ifid_instr = c; ifid_valid = cv; idex_instr = p; idex_valid = pv;
        #1;
        ef = !r && model_raw(c, cv, p, pv, 1'b1) && !hist_f;
        en = !r && model_raw(c, cv, p, pv, 1'b0) && !hist_n;
        if (want_f >= 0) ef = (want_f != 0);
        if (want_n >= 0) en = (want_n != 0);
        chk({tag, " [fwd]"}, ef, pc_we_f, ifid_we_f, bub_f);
        chk({tag, " [nofwd]"}, en, pc_we_n, ifid_we_n, bub_n);
        @(posedge clk);
        hist_f = r ? 1'b0 : ef;
        hist_n = r ? 1'b0 : en;
    endtask

    task automatic idle();
        apply(1'b0, mk(6'b000010, 5'd0, 5'd0), 1'b1, mk(6'b000000, 5'd0, 5'd0), 1'b1, "idle");
    endtask

    task automatic dcase(logic [31:0] c, logic [31:0] p, int wf, int wn, string tag);
        idle();
        apply(1'b0, c, 1'b1, p, 1'b1, tag, wf, wn);
    endtask

    localparam logic [5:0] OPS [10] = '{6'b000000, 6'b000100, 6'b000101, 6'b100011,
                                        6'b100000, 6'b101011, 6'b001000, 6'b001111,
                                        6'b000010, 6'b111110};

    initial begin
        logic [31:0] ld3;
        void'($urandom(32'h00C0FFEE));
        ld3 = mk(6'b100011, 5'd7, 5'd3);

        // R9: reset holds the unit quiet even with a conflict present.
        apply(1'b1, mk(6'b000000, 5'd3, 5'd1), 1'b1, ld3, 1'b1, "R9 during reset", 0, 0);
        apply(1'b1, mk(6'b000000, 5'd3, 5'd1), 1'b1, ld3, 1'b1, "R9 during reset", 0, 0);

        // R1 and R8: stall, then release, then a fresh stall.
        apply(1'b0, mk(6'b000000, 5'd3, 5'd1), 1'b1, ld3, 1'b1, "R1 field A hit", 1, 1);
        apply(1'b0, mk(6'b000000, 5'd3, 5'd1), 1'b1, ld3, 1'b1, "R8 single bubble", 0, 0);
        apply(1'b0, mk(6'b000000, 5'd3, 5'd1), 1'b1, ld3, 1'b1, "R8 next conflict", 1, 1);
        // R9: a reset right after a stall clears the history.
        apply(1'b1, mk(6'b000000, 5'd3, 5'd1), 1'b1, ld3, 1'b1, "R9 reset after stall", 0, 0);
        apply(1'b0, mk(6'b000000, 5'd3, 5'd1), 1'b1, ld3, 1'b1, "R9 stall after reset", 1, 1);

        dcase(mk(6'b000000, 5'd3, 5'd1), mk(6'b000000, 5'd9, 5'd3), 0, 0, "R1 non-load producer");
        dcase(mk(6'b100011, 5'd3, 5'd9), ld3, 1, 1, "R1 load uses load");
        dcase(mk(6'b000000, 5'd1, 5'd3), ld3, 1, 1, "R2 regreg field B");
        dcase(mk(6'b000101, 5'd1, 5'd3), ld3, 1, 1, "R2 branch field B");
        dcase(mk(6'b101011, 5'd1, 5'd3), ld3, 0, 1, "R3 store data match");
        dcase(mk(6'b101011, 5'd3, 5'd1), ld3, 1, 1, "R3 store base match");
        dcase(mk(6'b000000, 5'd0, 5'd0), mk(6'b100011, 5'd7, 5'd0), 0, 0, "R4 zero destination");
        idle();
        apply(1'b0, mk(6'b000000, 5'd3, 5'd3), 1'b0, ld3, 1'b1, "R5 ifid invalid", 0, 0);
        apply(1'b0, mk(6'b000000, 5'd3, 5'd3), 1'b1, ld3, 1'b0, "R5 idex invalid", 0, 0);
        dcase(mk(6'b000010, 5'd3, 5'd3), ld3, 0, 0, "R6 jump");
        dcase(mk(6'b001111, 5'd3, 5'd3), ld3, 0, 0, "R6 upper immediate");
        dcase(mk(6'b001000, 5'd3, 5'd1), ld3, 1, 1, "R6 alu-imm field A");
        dcase(mk(6'b001000, 5'd1, 5'd3), ld3, 0, 0, "R6 alu-imm field B ignored");
        dcase(mk(6'b100011, 5'd1, 5'd3), ld3, 0, 0, "R6 load field B ignored");
        dcase(mk(6'b000100, 5'd3, 5'd3), ld3, 1, 1, "R7 freeze outputs");

        // Random mix checked against the model (R1-related classes, R7, R8).
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] c, p;
            bit r, cv, pv;
            c  = mk(OPS[$urandom_range(0, 9)], 5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)));
            p  = mk(OPS[$urandom_range(0, 9)], 5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)));
            cv = ($urandom_range(0, 7) != 0);
            pv = ($urandom_range(0, 7) != 0);
            r  = ($urandom_range(0, 63) == 0);
            apply(r, c, cv, p, pv, "R7 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule